// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a bank of port input pins and asks the host for attention when any of them moves. It keeps a reference snapshot of the pin levels. While the synchronized pins differ from that snapshot, it drives an interrupt pull-down enable, which becomes an active-low, open-drain request line at the pad. If the pins return to the snapshot levels before the host acts, the request goes away by itself.

The bus interface tells the block when the host reads or writes the ports, using a read strobe and a write strobe. A read clears the request on the strobe's rising edge. A write clears it from the rising edge through the cycle after the falling edge. During a clear the snapshot tracks the pins, so pin changes inside the clear window are absorbed and raise nothing. Once the window closes, any new difference is reported again. After reset the block primes the snapshot from the pins and keeps the line released, so pins that start at non-zero levels do not cause a false request.

Top module: `port_change_irq`

## Requirements
- R1: While reset is high, and for the priming cycles after it falls, `int_pd_en` stays 0 whatever the pin levels. After priming, the snapshot equals the pin levels, so static pins never assert the request.
- R2: A rising or a falling change on any single pin, outside a clear, sets `int_pd_en` to 1 at the third rising clock edge after the change. Two of those edges are synchronizer stages and one is the output register.
- R3: When every pin returns to its snapshot level, `int_pd_en` goes back to 0 with the same three-edge latency, with no host access.
- R4: A rising edge of `rd_strobe` (high now, low in the cycle before) clears `int_pd_en` at that edge and reloads the snapshot. Keeping `rd_strobe` high for more cycles does not clear again.
- R5: From the first cycle `wr_strobe` is high through the first cycle it is low again, each clock edge clears `int_pd_en` and reloads the snapshot.
- R6: A pin change that reaches the synchronizer output inside a clear window is absorbed into the snapshot and raises no request after the window.
- R7: After a clear has finished, a later pin change is detected and signalled again as in R2.
- R8: `int_pd_en` is a registered output, where 1 means the open-drain line is pulled low (request active) and 0 means it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | PIN_W (16) | Port pin levels, asynchronous to clk |
| rd_strobe | input | 1 | High while the host reads the ports (synchronous to clk) |
| wr_strobe | input | 1 | High while the host writes the ports (synchronous to clk) |
| int_pd_en | output | 1 | Pull-down enable for the active-low interrupt line |

## Verification
The hardest case to reach from the ports is a pin change that lands inside the synchronizer while a write window is closing. Such a change may be absorbed into the snapshot or reported just after the window, depending on the edge where it appears at the synchronizer output. The stimulus toggles pins in the cycles around the falling edge of the write strobe, and mixes long random runs of sparse pin changes with overlapping read and write strobes. A cycle-accurate behavioural model decides, edge by edge, which of the two outcomes is correct.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;

  // Clear sequencing states
  typedef enum logic [1:0] {
    CLR_PRIME = 2'd0,  // after reset: load snapshot while synchronizer fills
    CLR_RUN   = 2'd1,  // normal watching
    CLR_WRITE = 2'd2   // write access in progress (through the fall cycle)
  } clr_state_e;

  localparam int unsigned MIN_SYNC = 2;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/clear_ctrl.sv
module clear_ctrl
  import port_irq_pkg::*;
#(
  parameter int unsigned PRIME_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe,
  input  logic wr_strobe,
  output logic clear_now
);

  localparam int unsigned CW = $clog2(PRIME_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PRIME_CYCLES);

  clr_state_e    state_q;
  logic [CW-1:0] prime_cnt_q;
  logic          rd_q;
  logic          rd_rise;

  assign rd_rise = rd_strobe & ~rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= CLR_PRIME;
      prime_cnt_q <= '0;
      rd_q        <= 1'b0;
    end else begin
      rd_q <= rd_strobe;
      unique case (state_q)
        CLR_PRIME: begin
          if (prime_cnt_q == CNT_LAST) state_q <= wr_strobe ? CLR_WRITE : CLR_RUN;
          else                         prime_cnt_q <= prime_cnt_q + 1'b1;
        end
        CLR_RUN: begin
          if (wr_strobe) state_q <= CLR_WRITE;
        end
        CLR_WRITE: begin
          if (!wr_strobe) state_q <= CLR_RUN;
        end
        default: state_q <= CLR_PRIME;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      CLR_RUN: clear_now = wr_strobe | rd_rise;
      default: clear_now = 1'b1;
    endcase
  end

endmodule

// File: rtl/snap_compare.sv
module snap_compare #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_s,
  input  logic             clear_now,
  output logic             irq_flag
);

  logic [WIDTH-1:0] snap_q;
  logic [WIDTH-1:0] diff;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_diff
      assign diff[b] = pins_s[b] ^ snap_q[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q   <= '0;
      irq_flag <= 1'b0;
    end else if (clear_now) begin
      snap_q   <= pins_s;
      irq_flag <= 1'b0;
    end else begin
      irq_flag <= |diff;
    end
  end

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import port_irq_pkg::*;
#(
  parameter int unsigned PIN_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pin_async,
  input  logic             rd_strobe,
  input  logic             wr_strobe,
  output logic             int_pd_en
);

  localparam int unsigned STAGES = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

  logic [PIN_W-1:0] pins_s;
  logic             clear_now;

  pin_sync #(.WIDTH(PIN_W), .STAGES(STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(pin_async),
    .d_sync (pins_s)
  );

  clear_ctrl #(.PRIME_CYCLES(STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe),
    .clear_now(clear_now)
  );

  snap_compare #(.WIDTH(PIN_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .pins_s   (pins_s),
    .clear_now(clear_now),
    .irq_flag (int_pd_en)
  );

endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
  parameter int unsigned PIN_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [PIN_W-1:0] pin_async,
  input logic             rd_strobe,
  input logic             wr_strobe,
  input logic             int_pd_en
);

  logic [7:0] age_q;
  logic       rd_d, wr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
      rd_d  <= 1'b0;
      wr_d  <= 1'b0;
    end else begin
      if (age_q != 8'hFF) age_q <= age_q + 8'd1;
      rd_d <= rd_strobe;
      wr_d <= wr_strobe;
    end
  end

  // R1
  prime_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q <= 8'(SYNC_STAGES + 1)) |-> !int_pd_en);

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !rd_d) |=> !int_pd_en);

  // R5
  write_high_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !int_pd_en);

  // R5
  write_fall_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_d && !wr_strobe) |=> !int_pd_en);

  // R8
  int_known_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(int_pd_en));

endmodule

bind port_change_irq port_change_irq_chk #(
  .PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .pin_async(pin_async),
  .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .int_pd_en(int_pd_en)
);

// File: tb/port_change_irq_tb.sv
module port_change_irq_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin_async = 16'hA5C3;
  logic         rd_strobe = 1'b0;
  logic         wr_strobe = 1'b0;
  logic         int_pd_en;

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  port_change_irq #(.PIN_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .pin_async(pin_async),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .int_pd_en(int_pd_en)
  );

  // Behavioural reference: pin history queue, edge counter, strobe memory
  logic [W-1:0] hist[$];
  logic [W-1:0] m_snap = '0;
  bit   m_int = 1'b0;
  int   since_rst = 0;
  bit   rd_prev = 1'b0, wr_prev = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      hist = {16'h0, 16'h0};
      m_snap = '0; m_int = 1'b0; since_rst = 0;
      rd_prev = 1'b0; wr_prev = 1'b0;
    end else begin
      logic [W-1:0] seen;
      bit clr;
      since_rst++;
      seen = hist[1];
      clr = (since_rst <= 3) || (rd_strobe && !rd_prev) || wr_strobe || wr_prev;
      if (clr) begin m_snap = seen; m_int = 1'b0; end
      else m_int = (seen != m_snap);
      void'(hist.pop_back());
      hist.push_front(pin_async);
      rd_prev = rd_strobe; wr_prev = wr_strobe;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (int_pd_en !== m_int) begin
        n_fail++;
        $display("FAIL %s model: int_pd_en=%0b expected=%0b at %0t", tag, int_pd_en, m_int, $time);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_int(bit exp, string req);
    n_tests++;
    if (int_pd_en !== exp) begin
      n_fail++;
      $display("FAIL %s directed: int_pd_en=%0b expected=%0b at %0t", req, int_pd_en, exp, $time);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset with non-zero static pins
    tag = "R1";
    cyc(4);
    expect_int(1'b0, "R1");
    rst = 1'b0;
    cyc(10);
    expect_int(1'b0, "R1");

    // R2: single bit rise (bit 2 is 0 in A5C3)
    tag = "R2";
    pin_async[2] = 1'b1;
    cyc(2);
    expect_int(1'b0, "R2");
    cyc(1);
    expect_int(1'b1, "R2");

    // R3: return to snapshot
    tag = "R3";
    pin_async[2] = 1'b0;
    cyc(4);
    expect_int(1'b0, "R3");

    // R2: single bit fall (bit 15 is 1)
    tag = "R2";
    pin_async[15] = 1'b0;
    cyc(4);
    expect_int(1'b1, "R2");

    // R4: read pulse clears and reloads snapshot
    tag = "R4";
    rd_strobe = 1'b1;
    cyc(1);
    expect_int(1'b0, "R4");
    cyc(4);
    // R4: held read does not clear a new change
    pin_async[7] = ~pin_async[7];
    cyc(4);
    expect_int(1'b1, "R4");
    rd_strobe = 1'b0;
    cyc(3);

    // R5/R6: write window absorbs changes
    tag = "R5";
    wr_strobe = 1'b1;
    cyc(1);
    expect_int(1'b0, "R5");
    tag = "R6";
    pin_async = 16'h1234;
    cyc(2);
    pin_async = 16'hFFFF;
    cyc(4);
    expect_int(1'b0, "R5");
    wr_strobe = 1'b0;
    cyc(1);
    expect_int(1'b0, "R5");
    cyc(6);
    expect_int(1'b0, "R6");

    // R7: detection resumes after the clear
    tag = "R7";
    pin_async[0] = 1'b0;
    cyc(4);
    expect_int(1'b1, "R7");

    // R6: change right at the fall of the write strobe
    tag = "R6";
    wr_strobe = 1'b1;
    cyc(3);
    pin_async[1] = ~pin_async[1];
    wr_strobe = 1'b0;
    cyc(8);

    // R8 and all: random traffic against the model
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 6) == 0) pin_async[$urandom % W] = ~pin_async[$urandom % W];
      if (($urandom % 25) == 0) rd_strobe = ~rd_strobe;
      if (($urandom % 30) == 0) wr_strobe = ~wr_strobe;
      cyc(1);
    end
    rd_strobe = 1'b0; wr_strobe = 1'b0;
    cyc(5);

    // R1: reset again mid-run
    tag = "R1";
    rst = 1'b1;
    pin_async = 16'h0F0F;
    cyc(3);
    rst = 1'b0;
    cyc(6);
    expect_int(1'b0, "R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule